// File: doc/BRIEF.md
# Configurable Registered I/O Macrocell

This block is one output cell of a programmable logic array. A vector of product terms arrives from the term allocator. A steering mask chooses which of those terms belong to this cell, and the chosen terms are ORed into one sum. A polarity bit can invert the sum. The cell then sends the result to the pin in one of three ways: directly as combinational logic, through an edge-triggered flip-flop, or through a level-sensitive latch.

The flip-flop or latch is timed by one of several global clocks, chosen by a static select field. In latch mode, the selected clock acts as the latch enable. Asynchronous clear and set inputs override the storage element at any time, and clear has priority over set.

The pin value goes out together with a tri-state enable. A feedback output returns a signal to the interconnect. It carries either the cell's internal result or the level seen on the pad. Because of this, the storage element stays usable as a buried node when the pin serves as an input.

Top module: `io_macrocell`

## Requirements
- R1: The summed term is 1 when at least one bit position has both `pt_in` and `pt_mask` high. When the mask is all zeros, the sum is 0 whatever `pt_in` holds.
- R2: With `cfg_invert`=1 the data term is the complement of the sum. An empty mask with inversion therefore gives a constant 1.
- R3: With `cfg_mode`=2'b00 (bypass), `pin_out` equals the data term in the same cycle, with no clock involved.
- R4: With `cfg_mode`=2'b01 or 2'b11 (register), the stored value takes the data term on each rising edge of the selected clock. It holds that value between rising edges, and `pin_out` shows it.
- R5: `cfg_clk_sel`=k selects `gclk[k]` as the register clock or latch enable. Edges on the other clocks have no effect on the stored value.
- R6: With `cfg_mode`=2'b10 (latch), the stored value follows the data term while the selected clock is high. It keeps the last value while that clock is low.
- R7: `arst` high forces the stored value to 0, and `apre` high forces it to 1, both without a clock edge. When both are high, the result is 0.
- R8: `pin_oe` equals `oe_term`. The enable has no effect on `pin_out` or on the stored value.
- R9: With `cfg_fb_pin`=0, `fb_out` equals the value driven to `pin_out` (the stored value, or the data term in bypass), even while `pin_oe` is 0. With `cfg_fb_pin`=1, `fb_out` equals `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pt_in | input | PT_W | Product terms from the allocator |
| pt_mask | input | PT_W | Steering mask; a 1 assigns that term to this cell |
| gclk | input | CLK_N | Global clocks |
| arst | input | 1 | Asynchronous clear of the storage element, active high |
| apre | input | 1 | Asynchronous set of the storage element, active high |
| oe_term | input | 1 | Output-enable term for the pin driver |
| pin_in | input | 1 | Level sensed on the pad |
| cfg_invert | input | 1 | Polarity: 1 inverts the summed term |
| cfg_mode | input | 2 | 00 bypass, 01/11 register, 10 latch |
| cfg_clk_sel | input | CSEL_W | Index of the global clock used |
| cfg_fb_pin | input | 1 | Feedback source: 0 internal result, 1 pad level |
| pin_out | output | 1 | Value for the pin driver |
| pin_oe | output | 1 | Tri-state enable for the pin driver |
| fb_out | output | 1 | Feedback to the interconnect |

## Verification
The assertions assume several things about the inputs. The configuration fields change only while `arst` is held. Clear and set are released together when both were raised. Product terms move away from edges of the selected clock, so each edge and each latch-closing edge sees settled data.

The stimulus keeps to these assumptions in three ways. Every configuration change is wrapped in a clear pulse. All data and control inputs move one nanosecond after the main clock edge, while the derived clocks change only at edges of the main clock. Async pulses are held across a whole cycle, and overlapping pulses are dropped together.

// File: rtl/io_macrocell.sv
module io_macrocell #(
  parameter int PT_W  = 16,
  parameter int CLK_N = 4,
  localparam int CSEL_W = (CLK_N > 1) ? $clog2(CLK_N) : 1
) (
  input  logic [PT_W-1:0]   pt_in,
  input  logic [PT_W-1:0]   pt_mask,
  input  logic [CLK_N-1:0]  gclk,
  input  logic              arst,
  input  logic              apre,
  input  logic              oe_term,
  input  logic              pin_in,
  input  logic              cfg_invert,
  input  logic [1:0]        cfg_mode,
  input  logic [CSEL_W-1:0] cfg_clk_sel,
  input  logic              cfg_fb_pin,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              fb_out
);

  localparam logic [1:0] MODE_BYP = 2'b00;
  localparam logic [1:0] MODE_LAT = 2'b10;

  logic sum_term, d_term, clk_sel;
  logic reg_q, lat_q, store_q, core_out;

  assign sum_term = |(pt_in & pt_mask);
  assign d_term   = sum_term ^ cfg_invert;
  assign clk_sel  = gclk[cfg_clk_sel];

  always_ff @(posedge clk_sel or posedge arst or posedge apre) begin
    if (arst)      reg_q <= 1'b0;
    else if (apre) reg_q <= 1'b1;
    else           reg_q <= d_term;
  end

  always_latch begin
    if (arst)         lat_q <= 1'b0;
    else if (apre)    lat_q <= 1'b1;
    else if (clk_sel) lat_q <= d_term;
  end

  assign store_q  = (cfg_mode == MODE_LAT) ? lat_q : reg_q;
  assign core_out = (cfg_mode == MODE_BYP) ? d_term : store_q;
  assign pin_out  = core_out;
  assign pin_oe   = oe_term;
  assign fb_out   = cfg_fb_pin ? pin_in : core_out;

  AST_REG_CAPTURE: assert property (@(posedge clk_sel) disable iff (arst || apre)
    (cfg_mode[0]) |=> (pin_out == $past(d_term)));  // R4

  AST_LATCH_OPEN: assert property (@(negedge clk_sel) disable iff (arst || apre)
    (cfg_mode == MODE_LAT) |-> (pin_out == d_term));  // R6

  AST_PRESET_SETS: assert property (@(posedge clk_sel) disable iff (arst)
    (apre && cfg_mode != MODE_BYP) |-> (store_q == 1'b1));  // R7

  AST_BURIED_FB: assert property (@(posedge clk_sel) disable iff (arst || apre)
    (cfg_mode[0] && !oe_term && !cfg_fb_pin) |=> (fb_out == $past(d_term)));  // R9

  always @(negedge clk_sel) begin
    if (arst) begin
      AST_CLEAR_WINS: assert (store_q == 1'b0);  // R7
    end
  end

endmodule

// File: tb/io_macrocell_tb.sv
module io_macrocell_tb;
  localparam int PT_W = 16;
  localparam int CLK_N = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] div = 2'b00;
  always @(posedge clk) div <= div + 2'b01;

  logic [CLK_N-1:0] gclk;
  assign gclk = {div[1], div[0], ~clk, clk};

  logic [PT_W-1:0] pt_in = '0, pt_mask = '0;
  logic arst = 1'b1, apre = 1'b0, oe_term = 1'b0, pin_in = 1'b0;
  logic cfg_invert = 1'b0, cfg_fb_pin = 1'b0;
  logic [1:0] cfg_mode = 2'b01, cfg_clk_sel = 2'b00;
  logic pin_out, pin_oe, fb_out;

  io_macrocell #(.PT_W(PT_W), .CLK_N(CLK_N)) u_dut (
    .pt_in(pt_in), .pt_mask(pt_mask), .gclk(gclk), .arst(arst), .apre(apre),
    .oe_term(oe_term), .pin_in(pin_in), .cfg_invert(cfg_invert),
    .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel), .cfg_fb_pin(cfg_fb_pin),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out));

  // behavioural reference
  function automatic logic ref_data(logic [PT_W-1:0] p, logic [PT_W-1:0] m, logic inv);
    logic hit = 1'b0;
    for (int i = 0; i < PT_W; i++) if (p[i] === 1'b1 && m[i] === 1'b1) hit = 1'b1;
    return hit ^ inv;
  endfunction

  logic m_clk, m_d, m_reg, m_lat;
  assign m_clk = gclk[cfg_clk_sel];
  assign m_d   = ref_data(pt_in, pt_mask, cfg_invert);

  always @(posedge m_clk or posedge arst or posedge apre)
    if (arst) m_reg = 1'b0; else if (apre) m_reg = 1'b1; else m_reg = m_d;

  always @* begin
    if (arst) m_lat = 1'b0;
    else if (apre) m_lat = 1'b1;
    else if (m_clk) m_lat = m_d;
  end

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic compare(string req);
    logic e_out, e_fb;
    e_out = (cfg_mode == 2'b00) ? m_d : ((cfg_mode == 2'b10) ? m_lat : m_reg);
    e_fb  = cfg_fb_pin ? pin_in : e_out;
    n_vec++;
    if (pin_out !== e_out || pin_oe !== oe_term || fb_out !== e_fb) begin
      n_bad++;
      $display("FAIL %s: out/oe/fb actual %b%b%b expected %b%b%b", req,
               pin_out, pin_oe, fb_out, e_out, oe_term, e_fb);
    end
  endtask

  task automatic step(string req);
    #7; compare(req);
    @(posedge clk); #1;
  endtask

  task automatic setup(logic [1:0] mode, logic [1:0] sel, logic inv, logic fbp);
    arst = 1'b1; apre = 1'b0;
    step("R7");
    cfg_mode = mode; cfg_clk_sel = sel; cfg_invert = inv; cfg_fb_pin = fbp;
    step("R7");
    arst = 1'b0;
  endtask

  task automatic burst(int n, string req, bit empty_mask);
    for (int i = 0; i < n; i++) begin
      pt_in   = PT_W'($urandom);
      pt_mask = empty_mask ? '0 : PT_W'($urandom & $urandom & $urandom);
      oe_term = 1'(($urandom));
      pin_in  = 1'(($urandom));
      step(req);
    end
  endtask

  initial begin
    @(posedge clk); #1;
    step("R7"); step("R7");                 // reset state, register mode
    if (pin_out !== 1'b0) begin n_bad++; $display("FAIL R7: reset pin_out actual %b expected 0", pin_out); end
    n_vec++;

    setup(2'b00, 2'd0, 1'b0, 1'b0);
    burst(40, "R3", 0);
    burst(10, "R1", 1);
    setup(2'b00, 2'd0, 1'b1, 1'b0);
    burst(10, "R2", 1);
    burst(20, "R2", 0);

    for (int s = 0; s < CLK_N; s++) begin
      setup(2'b01, 2'(s), 1'b0, 1'b0);
      burst(40, "R5", 0);
    end
    setup(2'b11, 2'd2, 1'b1, 1'b0);
    burst(30, "R4", 0);

    for (int s = 0; s < CLK_N; s++) begin
      setup(2'b10, 2'(s), 1'b0, 1'b0);
      burst(30, "R6", 0);
    end

    for (int k = 0; k < 2; k++) begin
      setup(k ? 2'b10 : 2'b01, 2'd0, 1'b0, 1'b0);
      pt_mask = '1; pt_in = '1;
      step("R7");
      arst = 1'b1; step("R7"); step("R7"); arst = 1'b0;
      pt_in = '0; step("R7");
      apre = 1'b1; step("R7"); step("R7"); apre = 1'b0;
      step("R7");
      apre = 1'b1; arst = 1'b1; step("R7"); step("R7");
      apre = 1'b0; arst = 1'b0;
      burst(10, "R7", 0);
    end

    setup(2'b01, 2'd1, 1'b0, 1'b1);
    burst(40, "R9", 0);
    setup(2'b01, 2'd0, 1'b0, 1'b0);
    oe_term = 1'b0;
    for (int i = 0; i < 30; i++) begin
      pt_in = PT_W'($urandom); pt_mask = PT_W'($urandom); pin_in = 1'(($urandom));
      step("R9");
    end
    setup(2'b00, 2'd0, 1'b1, 1'b0);
    burst(30, "R8", 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule